// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a wide binary up-counter built from identical 4-bit slices. Each slice holds its value in flip-flops that all update on the rising clock edge. Each slice has a synchronous active-low clear, a synchronous active-low parallel load and two count enables. One enable, the propagate enable, only allows counting. The other, the carry enable, allows counting and also gates the slice's carry output. The carry output goes high when the slice holds all ones and its carry enable is high. That output feeds the carry enable of the next slice up, with no gating between slices, so the chain counts as one synchronous n-bit counter.

The top level drives every slice's propagate enable from one shared input. The outside carry enable goes only to the lowest slice. The highest slice's carry output becomes the counter's carry. A build-time option shortens the count length: it decodes one chosen terminal value from the outputs and feeds it back into the clear path. The counter then returns to zero on the edge after it reaches that value. A synchronous active-high reset also zeroes the count.

Top module: `cnt_chain`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros after that edge, and `carry_out` is then low.
- R2: When `clr_n` is low at a rising edge, `q` becomes zero after that edge, whatever the levels of `load_n`, `en_p` and `en_t`. Clear outranks load.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge, whatever the levels of the enables.
- R4: When `clr_n` and `load_n` are both high, `q` rises by one at an edge only if both `en_p` and `en_t` are high. Otherwise `q` keeps its value.
- R5: `carry_out` is high exactly when `q` is all ones and `en_t` is high. Its value does not depend on `en_p`.
- R6: Counting carries across slice boundaries as one n-bit binary counter: from each 4-bit boundary value the next enabled count gives the correct n-bit successor, and all ones wraps to zero.
- R7: With the truncation option on (`TRUNC_EN`=1), a `q` equal to `TERM` at a rising edge gives zero after that edge, whatever the levels of load and the enables. The count therefore cycles through `TERM`+1 states.
- R8: A load that falls in the same cycle as an enabled count, including the case where lower slices are at all ones and would carry, gives exactly `din` in every slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Synchronous active-low clear |
| load_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Count enable shared by all slices |
| en_t | input | 1 | Count enable of the lowest slice; also gates the carry |
| din | input | NSLICE*SLICE_W | Parallel load value |
| q | output | NSLICE*SLICE_W | Registered count |
| carry_out | output | 1 | High at all ones while `en_t` is high |

## Verification
The counter is first driven with directed patterns. A plain enabled run from zero checks the basic increment. Loads just below slice boundaries and just below all ones show whether carries cross slices and whether the counter wraps at the top. Holding at all ones while toggling `en_p` and `en_t` separates the carry enable's effect on the carry output from its effect on counting. Clear and load asserted together, and a load that meets a pending carry, expose a wrong priority. A long stretch of random clear, load and enable stimulus then runs on both the full-length counter and a truncated counter. This tells a right terminal decode from one that is off by a cycle, or one that gives way to load.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } slice_op_e;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  slice_op_e op;

  // Fixed priority: clear, then load, then count.
  always_comb begin
    if (rst || !clr_n)       op = OP_CLEAR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_COUNT;
    else                     op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= d;
      OP_COUNT: q <= q + W'(1);
      default:  q <= q;
    endcase
  end

  // Look-ahead carry: gated by the carry enable only.
  assign rco = en_t & (&q);

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (q == $past(d)));
  assert_count_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t) |=> (q == $past(q) + W'(1)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/cnt_term_decode.sv
module cnt_term_decode #(
  parameter int N        = 12,
  parameter bit TRUNC_EN = 1'b0,
  parameter int TERM     = 0
) (
  input  logic [N-1:0] q,
  input  logic         clr_n,
  output logic         clr_eff_n
);
  localparam logic [N-1:0] TERM_V = N'(TERM);

  generate
    if (TRUNC_EN) begin : g_trunc
      assign clr_eff_n = clr_n & (q != TERM_V);
    end else begin : g_full
      logic [N-1:0] unused_q;
      assign unused_q  = q;
      assign clr_eff_n = clr_n;
    end
  endgenerate
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int NSLICE   = 3,
  parameter int SLICE_W  = 4,
  parameter bit TRUNC_EN = 1'b0,
  parameter int TERM     = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      en_p,
  input  logic                      en_t,
  input  logic [NSLICE*SLICE_W-1:0] din,
  output logic [NSLICE*SLICE_W-1:0] q,
  output logic                      carry_out
);
  localparam int N = NSLICE * SLICE_W;
  localparam logic [N-1:0] TERM_V = N'(TERM);

  logic              clr_eff_n;
  logic [NSLICE:0]   t_chain;

  cnt_term_decode #(.N(N), .TRUNC_EN(TRUNC_EN), .TERM(TERM)) u_dec (
    .q(q), .clr_n(clr_n), .clr_eff_n(clr_eff_n)
  );

  assign t_chain[0] = en_t;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    cnt_slice #(.W(SLICE_W)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .clr_n  (clr_eff_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (t_chain[i]),
      .d      (din[i*SLICE_W +: SLICE_W]),
      .q      (q[i*SLICE_W +: SLICE_W]),
      .rco    (t_chain[i+1])
    );
  end

  assign carry_out = t_chain[NSLICE];

  assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> (en_t && (&q)));
  assert_nocarry_R5: assert property (@(posedge clk) disable iff (rst)
    (en_t && (&q)) |-> carry_out);
  assert_wide_count_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_eff_n && load_n && en_p && en_t) |=> (q == $past(q) + N'(1)));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (q == '0));

  generate
    if (TRUNC_EN) begin : g_trunc_chk
      assert_term_R7: assert property (@(posedge clk) disable iff (rst)
        (q == TERM_V) |=> (q == '0));
    end
  endgenerate
endmodule

// File: tb/tb_cnt_chain.sv
module tb_cnt_chain;
  localparam int NSLICE = 3;
  localparam int SW     = 4;
  localparam int N      = NSLICE * SW;
  localparam int TERM   = 25;
  localparam logic [N-1:0] TERM_V = N'(TERM);

  typedef struct packed {
    logic [N-1:0] q1;
    logic         c1;
    logic [N-1:0] q2;
    logic         c2;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [N-1:0] din = '0;
  logic [N-1:0] q1, q2;
  logic         c1, c2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [N-1:0] m1 = '0, m2 = '0;

  always #4 clk = ~clk;

  cnt_chain #(.NSLICE(NSLICE), .SLICE_W(SW), .TRUNC_EN(1'b0), .TERM(TERM)) dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q1), .carry_out(c1)
  );

  cnt_chain #(.NSLICE(NSLICE), .SLICE_W(SW), .TRUNC_EN(1'b1), .TERM(TERM)) dut_mod (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q2), .carry_out(c2)
  );

  task automatic drive(input logic r, input logic c, input logic l,
                       input logic p, input logic t, input logic [N-1:0] d);
    exp_t  e;
    string tag;
    @(negedge clk);
    rst = r; clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    if (r)                tag = "R1";
    else if (!c)          tag = "R2";
    else if (!l)          tag = (p && t) ? "R8" : "R3";
    else if (p && t && (m1[SW-1:0] == '1)) tag = "R6";
    else                  tag = "R4";
    if (r || !c)          m1 = '0;
    else if (!l)          m1 = d;
    else if (p && t)      m1 = m1 + N'(1);
    if (r || !c || (m2 == TERM_V)) m2 = '0;
    else if (!l)          m2 = d;
    else if (p && t)      m2 = m2 + N'(1);
    e.q1 = m1; e.c1 = t & (&m1);
    e.q2 = m2; e.c2 = t & (&m2);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic cmp(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: samples 2 ns after each rising edge, inputs still stable.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      cmp(tg, q1, e.q1);
      cmp("R5", N'(c1), N'(e.c1));
      cmp("R7", q2, e.q2);
      cmp("R7", N'(c2), N'(e.c2));
    end
  end

  initial begin
    drive(1, 1, 1, 1, 1, '0);                 // R1 reset
    drive(1, 1, 1, 0, 0, '0);
    for (int i = 0; i < 20; i++) drive(0, 1, 1, 1, 1, '0);   // R4 count
    drive(0, 1, 0, 0, 0, 12'h00E);            // R3 load, enables low
    for (int i = 0; i < 4; i++) drive(0, 1, 1, 1, 1, '0);    // R6 slice boundary
    drive(0, 1, 0, 1, 0, 12'h0FD);            // R3
    for (int i = 0; i < 5; i++) drive(0, 1, 1, 1, 1, '0);    // R6 crossing 0FF
    drive(0, 1, 0, 0, 1, 12'hFFE);            // R3
    drive(0, 1, 1, 1, 1, '0);                 // to FFF, carry R5
    drive(0, 1, 1, 0, 1, '0);                 // hold at FFF, carry stays R5
    drive(0, 1, 1, 0, 0, '0);                 // carry drops with en_t low R5
    drive(0, 1, 1, 1, 0, '0);                 // en_p alone: hold R4
    drive(0, 1, 1, 1, 1, '0);                 // wrap to 0 R6
    drive(0, 0, 0, 1, 1, 12'h123);            // clear beats load R2
    drive(0, 1, 0, 1, 1, 12'h0FF);
    drive(0, 1, 0, 1, 1, 12'hA5C);            // load meets carry R8
    drive(0, 1, 0, 1, 1, 12'h017);
    for (int i = 0; i < 6; i++) drive(0, 1, 1, 1, 1, '0);    // R7 passes TERM
    drive(0, 1, 0, 1, 1, TERM_V);
    drive(0, 1, 0, 1, 1, 12'h3C3);            // R7 terminal beats load
    for (int i = 0; i < 400; i++) begin
      int roll = $urandom_range(0, 99);
      drive(roll < 2, roll >= 2 && roll < 6 ? 1'b0 : 1'b1,
            (roll >= 6 && roll < 14) ? 1'b0 : 1'b1,
            $urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
            (roll % 2 == 0) ? N'($urandom_range(0, 40)) : N'($urandom));
    end
    drive(0, 1, 1, 0, 0, '0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule